// File: doc/BRIEF.md
# Receive Descriptor Ring Engine

This block takes received Ethernet frames as a byte stream and writes them into host buffers in a shared 16-bit word memory. A ring of receive descriptors in that memory describes the buffers. A descriptor is four consecutive words: the low 16 bits of the buffer byte address; a word whose upper byte holds the status flags and whose lower byte holds the upper 8 bits of the buffer address; the buffer size, written negated in 12 bits with bits 15:12 set; and the message length. The host arms a descriptor by setting its ownership flag. The engine fills the buffer and clears that flag to return the descriptor.

A frame longer than one buffer continues into the following descriptors. The frame's first descriptor is marked as the start and its last descriptor as the end. The last descriptor also carries the total length and any error flags. The CRC and framing checks are made upstream, and their results arrive with the last byte. The engine signals each completed frame with a one-cycle receive pulse. A frame dropped because no buffer was armed gives a one-cycle missed-frame pulse.

Top module: `rx_desc_ring`

## Requirements
- R1: At frame start the engine reads the words of descriptor `idx`, which start at word address `cfg_ring_base + 4*idx`. The buffer word address is `{word1[7:0], word0} >> 1`, and the buffer size in bytes is `4096 - word2[11:0]`. Bytes are stored big-endian, two per word. A trailing odd byte goes in bits 15:8 with bits 7:0 zero. The engine never reads and writes memory in the same cycle.
- R2: A clean frame that fits one buffer leaves the flag byte (word1 bits 15:8) at exactly 0x03, which is start 0x02 plus end 0x01. The lower byte of word1 is kept. Word3 holds the received byte count, counting the 4 check-sequence bytes as they arrive, in bits 11:0 with bits 15:12 zero.
- R3: A frame longer than its buffer continues in the next descriptor. Each intermediate descriptor is returned with flag byte 0x02 on the first descriptor or 0x00 on later ones, and its word3 is left untouched. Only the last descriptor gets the end flag and the total length.
- R4: A CRC failure sets flag 0x08 and a framing failure sets 0x20, on the last descriptor only. The summary flag 0x40 is set exactly when any of 0x20, 0x10, 0x08 or 0x04 is set.
- R5: If the descriptor at `idx` lacks ownership (flag 0x80) when a frame starts, the whole frame is consumed and discarded. Nothing is written, `idx` is unchanged, and `miss` pulses for one cycle. `miss` and `rint` are never high together.
- R6: If the chain reaches a descriptor without ownership in the middle of a frame, the last filled descriptor is closed with overflow 0x10, summary 0x40 and end 0x01. Its word3 holds the bytes stored. The rest of the frame is discarded, and the next frame starts at the unowned descriptor.
- R7: `idx` advances by one for every returned descriptor and wraps modulo `2^cfg_ring_log2`.
- R8: Writing the flag word of the last descriptor is the last write of a frame. `rint` is high for exactly one cycle, in the cycle right after that write.
- R9: After reset, `rint`, `miss`, `mem_rd`, `mem_we` and `rx_ready` are low and `idx` is 0.
- R10: `rx_ready` is low while descriptors are fetched or written. No byte is taken while a read is in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_ring_base | input | 23 | Word address of descriptor 0 |
| cfg_ring_log2 | input | 3 | Log2 of ring size (bits 15:13 of the host's ring-length word) |
| rx_valid | input | 1 | Stream byte valid |
| rx_ready | output | 1 | Engine accepts the byte this cycle |
| rx_data | input | 8 | Stream byte |
| rx_last | input | 1 | Byte is the last of the frame |
| rx_crc_err | input | 1 | CRC failed, valid with rx_last |
| rx_fram_err | input | 1 | Framing failed, valid with rx_last |
| mem_rd | output | 1 | Memory read request |
| mem_we | output | 1 | Memory write strobe |
| mem_addr | output | 23 | Memory word address |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Read data, valid the cycle after the clock edge that samples `mem_rd` |
| rint | output | 1 | One-cycle frame-received pulse |
| miss | output | 1 | One-cycle missed-frame pulse |

## Verification
Memory writes are registered and appear one cycle after the state that issues them. Each write is compared, on the clock it is visible, against the image a behavioural model builds before the frame is sent. `rint` must rise exactly one cycle after a flag write whose ownership bit is clear and whose end bit is set. `miss` comes one cycle after the third descriptor word returns. Because the counts of the two pulses and the full memory image are judged only once the engine is idle, sixteen cycles after the last byte is accepted, fetch latency cannot move a result out of its check window.

// File: rtl/rxr_pkg.sv
package rxr_pkg;
  localparam int AW    = 23;  // word address width (24-bit byte space)
  localparam int LEN_W = 12;  // message length field

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_RECV, ST_REL, ST_WLEN, ST_WFLG, ST_DONE, ST_DROP
  } rxr_state_t;
endpackage

// File: rtl/rxr_ring_ptr.sv
module rxr_ring_ptr #(
  parameter int IDX_W = 7,
  parameter int AW    = 23
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             adv,
  input  logic [AW-1:0]    ring_base,
  input  logic [2:0]       ring_log2,
  output logic [IDX_W-1:0] idx,
  output logic [AW-1:0]    dsc_addr
);
  logic [IDX_W-1:0] mask;

  assign mask     = (IDX_W'(1) << ring_log2) - IDX_W'(1);
  assign dsc_addr = ring_base + AW'({idx, 2'b00});

  always_ff @(posedge clk) begin
    if (rst)      idx <= '0;
    else if (adv) idx <= (idx + IDX_W'(1)) & mask;
  end
endmodule

// File: rtl/rxr_status.sv
module rxr_status (
  input  logic       clk,
  input  logic       rst,
  input  logic       clear,
  input  logic       end_ld,
  input  logic       crc_in,
  input  logic       fram_in,
  input  logic       set_oflo,
  input  logic       first,
  output logic       oflo,
  output logic [7:0] fin_flags
);
  logic crc_q, fram_q, err;

  assign err       = crc_q | fram_q | oflo;
  // OWN ERR FRAM OFLO CRC BUFF STP ENP
  assign fin_flags = {1'b0, err, fram_q, oflo, crc_q, 1'b0, first, 1'b1};

  always_ff @(posedge clk) begin
    if (rst || clear) begin
      crc_q  <= 1'b0;
      fram_q <= 1'b0;
      oflo   <= 1'b0;
    end else begin
      if (end_ld) begin
        crc_q  <= crc_in;
        fram_q <= fram_in;
      end
      if (set_oflo) oflo <= 1'b1;
    end
  end
endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
  import rxr_pkg::*;
#(
  parameter int IDX_W = 7,
  parameter int SPC_W = 13
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] cfg_ring_base,
  input  logic [2:0]    cfg_ring_log2,
  input  logic          rx_valid,
  output logic          rx_ready,
  input  logic [7:0]    rx_data,
  input  logic          rx_last,
  input  logic          rx_crc_err,
  input  logic          rx_fram_err,
  output logic          mem_rd,
  output logic          mem_we,
  output logic [AW-1:0] mem_addr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata,
  output logic          rint,
  output logic          miss
);
  rxr_state_t       st;
  logic [2:0]       fc;
  logic [AW-1:0]    cur_dsc, prev_dsc, wptr, dsc_addr;
  logic [7:0]       cur_hi, prev_hi, hold, fin_flags;
  logic [15:0]      cur_lo;
  logic             own_q, cur_first, prev_first, half, oflo;
  logic [SPC_W-1:0] space;
  logic [LEN_W-1:0] cnt;
  logic [IDX_W-1:0] idx;
  logic             accept, fill, adv, set_oflo;

  assign rx_ready = (st == ST_RECV) || (st == ST_DROP);
  assign accept   = (st == ST_RECV) && rx_valid;
  assign fill     = accept && !rx_last && (space == SPC_W'(1));
  assign adv      = fill || ((st == ST_WFLG) && !oflo);
  assign set_oflo = (st == ST_FETCH) && (fc == 3'd4) && !own_q && !cur_first;

  rxr_ring_ptr #(.IDX_W(IDX_W), .AW(AW)) u_ptr (
    .clk(clk), .rst(rst), .adv(adv), .ring_base(cfg_ring_base),
    .ring_log2(cfg_ring_log2), .idx(idx), .dsc_addr(dsc_addr)
  );

  rxr_status u_stat (
    .clk(clk), .rst(rst), .clear((st == ST_IDLE) && rx_valid),
    .end_ld(accept && rx_last), .crc_in(rx_crc_err), .fram_in(rx_fram_err),
    .set_oflo(set_oflo), .first(cur_first), .oflo(oflo), .fin_flags(fin_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; fc <= '0;
      mem_rd <= 1'b0; mem_we <= 1'b0; mem_addr <= '0; mem_wdata <= '0;
      rint <= 1'b0; miss <= 1'b0;
      cur_dsc <= '0; prev_dsc <= '0; wptr <= '0;
      cur_hi <= '0; prev_hi <= '0; hold <= '0; cur_lo <= '0;
      own_q <= 1'b0; cur_first <= 1'b0; prev_first <= 1'b0; half <= 1'b0;
      space <= '0; cnt <= '0;
    end else begin
      mem_rd <= 1'b0;
      mem_we <= 1'b0;
      rint   <= 1'b0;
      miss   <= 1'b0;
      case (st)
        ST_IDLE: if (rx_valid) begin
          cur_first <= 1'b1;
          cnt       <= '0;
          fc        <= '0;
          st        <= ST_FETCH;
        end
        ST_FETCH: begin
          fc <= fc + 3'd1;
          case (fc)
            3'd0: begin mem_rd <= 1'b1; mem_addr <= dsc_addr; cur_dsc <= dsc_addr; end
            3'd1: begin mem_rd <= 1'b1; mem_addr <= cur_dsc + AW'(1); end
            3'd2: begin mem_rd <= 1'b1; mem_addr <= cur_dsc + AW'(2); cur_lo <= mem_rdata; end
            3'd3: begin own_q <= mem_rdata[15]; cur_hi <= mem_rdata[7:0]; end
            default: begin
              wptr  <= AW'({cur_hi, cur_lo[15:1]});
              space <= SPC_W'(4096) - SPC_W'(mem_rdata[11:0]);
              half  <= 1'b0;
              if (!own_q) begin
                if (cur_first) begin
                  miss <= 1'b1;
                  st   <= ST_DROP;
                end else begin
                  cur_dsc   <= prev_dsc;
                  cur_hi    <= prev_hi;
                  cur_first <= prev_first;
                  st        <= ST_WLEN;
                end
              end else begin
                st <= cur_first ? ST_RECV : ST_REL;
              end
            end
          endcase
        end
        ST_REL: begin
          mem_we    <= 1'b1;
          mem_addr  <= prev_dsc + AW'(1);
          mem_wdata <= {6'b0, prev_first, 1'b0, prev_hi};
          st        <= ST_RECV;
        end
        ST_RECV: if (rx_valid) begin
          cnt   <= cnt + LEN_W'(1);
          space <= space - SPC_W'(1);
          if (half) begin
            mem_we    <= 1'b1;
            mem_addr  <= wptr;
            mem_wdata <= {hold, rx_data};
            wptr      <= wptr + AW'(1);
            half      <= 1'b0;
          end else if (rx_last) begin
            mem_we    <= 1'b1;
            mem_addr  <= wptr;
            mem_wdata <= {rx_data, 8'h00};
          end else begin
            hold <= rx_data;
            half <= 1'b1;
          end
          if (rx_last) begin
            st <= ST_WLEN;
          end else if (space == SPC_W'(1)) begin
            prev_dsc   <= cur_dsc;
            prev_hi    <= cur_hi;
            prev_first <= cur_first;
            cur_first  <= 1'b0;
            fc         <= '0;
            st         <= ST_FETCH;
          end
        end
        ST_WLEN: begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_dsc + AW'(3);
          mem_wdata <= 16'(cnt);
          st        <= ST_WFLG;
        end
        ST_WFLG: begin
          mem_we    <= 1'b1;
          mem_addr  <= cur_dsc + AW'(1);
          mem_wdata <= {fin_flags, cur_hi};
          st        <= ST_DONE;
        end
        ST_DONE: begin
          rint <= 1'b1;
          st   <= oflo ? ST_DROP : ST_IDLE;
        end
        ST_DROP: if (rx_valid && rx_last) st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/rx_desc_ring_chk.sv
module rx_desc_ring_chk (
  input logic        clk,
  input logic        rst,
  input logic        rx_ready,
  input logic        mem_rd,
  input logic        mem_we,
  input logic [15:0] mem_wdata,
  input logic        rint,
  input logic        miss
);
  AST_MISS_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    miss |=> !miss); // R5
  AST_EVENTS_APART: assert property (@(posedge clk) disable iff (rst)
    !(rint && miss)); // R5
  AST_RINT_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    rint |=> !rint); // R8
  AST_RINT_AFTER_FLAG: assert property (@(posedge clk) disable iff (rst)
    rint |-> ($past(mem_we) && !$past(mem_wdata[15]) && $past(mem_wdata[8]))); // R8
  AST_ERR_SUMMARY: assert property (@(posedge clk) disable iff (rst)
    rint |-> ($past(mem_wdata[14]) == ($past(mem_wdata[13]) | $past(mem_wdata[12]) |
                                      $past(mem_wdata[11]) | $past(mem_wdata[10])))); // R4
  AST_RD_WR_APART: assert property (@(posedge clk) disable iff (rst)
    !(mem_rd && mem_we)); // R1
  AST_NO_RD_WHILE_READY: assert property (@(posedge clk) disable iff (rst)
    rx_ready |-> !mem_rd); // R10
endmodule

bind rx_desc_ring rx_desc_ring_chk u_chk (
  .clk(clk), .rst(rst), .rx_ready(rx_ready), .mem_rd(mem_rd), .mem_we(mem_we),
  .mem_wdata(mem_wdata), .rint(rint), .miss(miss)
);

// File: tb/sim_rx_desc_ring.sv
module sim_rx_desc_ring;
  import rxr_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int MW   = 4096;
  localparam int BASE = 'h010;
  localparam logic [7:0] HI = 8'h5A;

  logic clk = 1'b0, rst = 1'b1;
  logic [AW-1:0] cfg_ring_base = AW'(BASE);
  logic [2:0]  cfg_ring_log2 = 3'd2;
  logic rx_valid = 0, rx_last = 0, rx_crc_err = 0, rx_fram_err = 0;
  logic [7:0] rx_data = 0;
  logic rx_ready, mem_rd, mem_we, rint, miss;
  logic [AW-1:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata = 0;

  logic [15:0] mem  [MW];
  logic [15:0] expm [MW];
  int vec = 0, bad = 0, cyc = 0;
  int rint_cnt = 0, miss_cnt = 0, e_rint = 0, e_miss = 0, rdy_rd = 0;
  int m_idx = 0, m_lg = 2;
  bit rint_seen = 0, prev_we = 0;
  logic [15:0] prev_wd = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  rx_desc_ring u0 (
    .clk(clk), .rst(rst), .cfg_ring_base(cfg_ring_base), .cfg_ring_log2(cfg_ring_log2),
    .rx_valid(rx_valid), .rx_ready(rx_ready), .rx_data(rx_data), .rx_last(rx_last),
    .rx_crc_err(rx_crc_err), .rx_fram_err(rx_fram_err), .mem_rd(mem_rd), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .rint(rint), .miss(miss)
  );

  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    if (mem_rd) mem_rdata <= mem[mem_addr[11:0]];
  end

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      bad++;
      $display("FAIL R10 watchdog: got hung run, exp completion");
      summary();
    end
  end

  // every-clock comparison of writes and pulses against the model
  always @(negedge clk) if (!rst) begin
    if (mem_we) begin
      vec++;
      if (mem_wdata !== expm[mem_addr[11:0]]) begin
        bad++;
        $display("FAIL R1 R2 R3 write @%h: got %h exp %h", mem_addr, mem_wdata, expm[mem_addr[11:0]]);
      end
      if (rint_seen) begin
        bad++;
        $display("FAIL R8 write after rint: got write @%h exp none", mem_addr);
      end
    end
    if (rint) begin
      rint_cnt++; rint_seen = 1; vec++;
      if (!(prev_we && !prev_wd[15] && prev_wd[8])) begin
        bad++;
        $display("FAIL R8 rint without final flag write: got we=%0b wd=%h exp flag write", prev_we, prev_wd);
      end
    end
    if (miss) miss_cnt++;
    if (rx_ready && mem_rd) rdy_rd++;
    prev_we = mem_we;
    prev_wd = mem_wdata;
  end

  function automatic int dsc(int d);
    return (BASE + 4*d) & 'hFFF;
  endfunction

  function automatic logic [7:0] bval(int seed, int i);
    return 8'((seed*31 + i*7 + 1) & 'hFF);
  endfunction

  task automatic check(string tag, int got, int exp);
    vec++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d exp %0d", tag, got, exp);
    end
  endtask

  task automatic init_ring(int lg, int size, int own_mask);
    m_lg = lg;
    cfg_ring_log2 = 3'(lg);
    for (int i = 0; i < (1 << lg); i++) begin
      logic [15:0] w0, w1, w2;
      w0 = 16'((('h100 + i*'h80) * 2) & 'hFFFF);
      w1 = {((own_mask >> i) & 1) ? 8'h80 : 8'h00, HI};
      w2 = 16'hF000 | 16'((-size) & 'hFFF);
      mem[dsc(i)] = w0;   expm[dsc(i)] = w0;
      mem[dsc(i)+1] = w1; expm[dsc(i)+1] = w1;
      mem[dsc(i)+2] = w2; expm[dsc(i)+2] = w2;
      mem[dsc(i)+3] = 0;  expm[dsc(i)+3] = 0;
    end
  endtask

  task automatic close_dsc(int d, int len, bit crc, bit fram, bit ofl, bit first);
    logic [7:0] f;
    f = {1'b0, crc | fram | ofl, fram, ofl, crc, 1'b0, first, 1'b1};
    expm[dsc(d)+3] = 16'(len & 'hFFF);
    expm[dsc(d)+1] = {f, expm[dsc(d)+1][7:0]};
    e_rint++;
  endtask

  // behavioural model of one frame
  task automatic model_frame(int len, bit crc, bit fram, int seed);
    int d = m_idx, pos = 0, mask = (1 << m_lg) - 1;
    bit first = 1;
    if (!expm[dsc(d)+1][15]) begin e_miss++; return; end
    forever begin
      int wa, cap, n, d2;
      wa  = int'({expm[dsc(d)+1][7:0], expm[dsc(d)]} >> 1) & 'hFFF;
      cap = 4096 - int'(expm[dsc(d)+2] & 16'h0FFF);
      n   = (len - pos < cap) ? len - pos : cap;
      for (int k = 0; k < n; k++) begin
        if (k % 2 == 0) expm[(wa + k/2) & 'hFFF] = {bval(seed, pos+k), 8'h00};
        else            expm[(wa + k/2) & 'hFFF][7:0] = bval(seed, pos+k);
      end
      pos += n;
      if (pos == len) begin
        close_dsc(d, len, crc, fram, 0, first);
        m_idx = (d + 1) & mask;
        return;
      end
      d2 = (d + 1) & mask;
      if (!expm[dsc(d2)+1][15]) begin
        close_dsc(d, pos, 0, 0, 1, first);
        m_idx = d2;
        return;
      end
      expm[dsc(d)+1] = {6'b0, first, 1'b0, expm[dsc(d)+1][7:0]};
      first = 0;
      d = d2;
    end
  endtask

  task automatic run_frame(int len, bit crc, bit fram, int seed, string tag);
    int mm = 0;
    rint_seen = 0; rdy_rd = 0;
    model_frame(len, crc, fram, seed);
    for (int i = 0; i < len; i++) begin
      rx_valid = 1; rx_data = bval(seed, i); rx_last = (i == len-1);
      rx_crc_err = crc && rx_last; rx_fram_err = fram && rx_last;
      while (!rx_ready) @(negedge clk);
      @(negedge clk);
    end
    rx_valid = 0; rx_last = 0; rx_crc_err = 0; rx_fram_err = 0;
    repeat (16) @(negedge clk);
    check({tag, " R8 rint count"}, rint_cnt, e_rint);
    check({tag, " R5 miss count"}, miss_cnt, e_miss);
    check({tag, " R10 read while ready"}, rdy_rd, 0);
    for (int a = 0; a < MW; a++)
      if (mem[a] !== expm[a]) begin
        if (mm < 4) $display("FAIL %s image @%h: got %h exp %h", tag, a, mem[a], expm[a]);
        mm++;
      end
    vec++;
    if (mm != 0) begin
      bad++;
      $display("FAIL %s image: got %0d differing words exp 0", tag, mm);
    end
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (3) @(negedge clk);
    rst = 0;
    m_idx = 0;
    check("R9 reset outputs", {rint, miss, mem_rd, mem_we, rx_ready}, 0);
  endtask

  initial begin
    for (int a = 0; a < MW; a++) begin mem[a] = 0; expm[a] = 0; end
    init_ring(2, 64, 'hF);
    do_reset();
    run_frame(20, 0, 0, 1, "R2 clean single");
    run_frame(21, 1, 0, 2, "R1 R4 odd crc");
    run_frame(30, 0, 1, 3, "R4 framing");
    init_ring(2, 64, 'hF);
    run_frame(150, 0, 0, 4, "R3 R7 chain wrap");
    run_frame(64, 1, 1, 5, "R4 exact fill both errors");
    init_ring(2, 64, 'h7);
    run_frame(10, 0, 0, 6, "R5 miss");
    init_ring(2, 64, 'hF);
    run_frame(10, 0, 0, 7, "R5 index held");
    run_frame(1, 0, 0, 8, "R1 one byte");
    init_ring(2, 16, 'hD);
    run_frame(40, 0, 0, 9, "R6 overflow");
    init_ring(2, 16, 'hF);
    run_frame(12, 0, 0, 10, "R6 resume at unowned");
    init_ring(0, 32, 'h1);
    do_reset();
    run_frame(18, 0, 0, 11, "R7 single entry ring");
    init_ring(0, 32, 'h1);
    run_frame(6, 0, 0, 12, "R7 single entry wrap");
    summary();
  end
endmodule